// File: doc/BRIEF.md
# Linked-list DMA descriptor walker

The walker runs a chain of DMA transfer descriptors kept in a descriptor memory, one channel at a time. Software loads the address of the first element through a small configuration write port. It sets the consumer cycle state and then rings a doorbell. From that point the walker reads each element through a word-read request/response port. For every data element it issues one transfer command, made of source address, destination address and byte count, to a data mover. The walker does not move data itself.

Every element takes a 24-byte slot in memory. A data element holds a control word, a byte count, a 64-bit source address and a 64-bit destination address. A link element holds a control word, an unused word and a 64-bit pointer to the next element. The walker uses an element only when that element's cycle bit matches the consumer cycle state. A link element can flip the consumer cycle state, so software can refill a ring and keep it running without resetting the channel. If a data element asks for it, the walker sends a one-cycle local or remote completion pulse once its command has been accepted.

Both stream edges use valid/ready handshakes. When the walker raises `mem_req_valid` or `cmd_valid`, it keeps the signal high and holds the payload unchanged until the matching ready is seen high at a clock edge. The memory response is a valid-only return: the walker always accepts it, and it has at most one read outstanding.

Top module: `lldma_walker`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `mem_req_valid`, `abort_seen`, `local_done`, `remote_done` and `cycle_state` are all 0.
- R2: Configuration writes while idle: offset 0 sets bits 31:0 of the list pointer, offset 1 sets bits 63:32, and offset 3 with data bit 0 set starts the walk at the list pointer. While `busy` is 1, writes to any offset are ignored.
- R3: A configuration write to offset 2 with data bit 1 set loads data bit 0 into the consumer cycle state, which is visible on `cycle_state`. With bit 1 clear, the state is unchanged.
- R4: Element words are read at byte addresses slot+4*k. A request stays valid with a stable address until it is accepted, and only one read is outstanding at a time.
- R5: A data element (control bit 2 clear) produces exactly one command with `cmd_len` = word 1, `cmd_src` = {word 3, word 2} and `cmd_dst` = {word 5, word 4}. The command is held stable until `cmd_ready`.
- R6: If control bit 0 of an element differs from the consumer cycle state, the walker issues nothing and returns to idle. The list pointer stays on that element, so the next doorbell resumes there.
- R7: A link element (control bit 2 set) continues the walk at {word 3, word 2}. If control bit 1 is set, the consumer cycle state is inverted; if it is clear, the state is kept.
- R8: Control bit 3 gives a one-cycle `local_done` and bit 4 a one-cycle `remote_done`, in the cycle right after the element's command handshake.
- R9: A data element with a byte count of zero sets `abort_seen`, issues no command and stops the walker. The next doorbell clears `abort_seen`.
- R10: After a data element's command is accepted, the next element is read at the slot address plus 24.
- R11: Source and destination addresses are passed through with no alignment check, odd byte addresses included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration offset: 0 pointer low, 1 pointer high, 2 cycle sync, 3 doorbell |
| cfg_wdata | input | 32 | Configuration write data |
| busy | output | 1 | Walker is fetching or issuing |
| cycle_state | output | 1 | Consumer cycle state |
| abort_seen | output | 1 | A zero-length element stopped the walk |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Descriptor read request accepted |
| mem_req_addr | output | ADDR_W | Byte address of the 32-bit word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_src | output | ADDR_W | Source byte address |
| cmd_dst | output | ADDR_W | Destination byte address |
| cmd_len | output | 32 | Transfer byte count |
| local_done | output | 1 | Local completion pulse |
| remote_done | output | 1 | Remote completion pulse |

## Verification
The bench builds the walker with the default `ADDR_W` of 64. This lets the upper words of source and destination addresses carry nonzero, odd-valued patterns that a narrower build would cut off. The bench's memory model decodes only the low 12 address bits and keeps descriptor rings in a 4 KB window. A stall mode drops both ready inputs on a fixed pattern, so the hold rules are exercised on both handshakes. A hold mode keeps the walker busy for as long as needed, which puts the ignored-while-busy configuration writes within reach.

// File: rtl/llw_pkg.sv
package llw_pkg;
  // Control word bit positions (element layout is fixed by the list format)
  localparam int CTL_CYCLE   = 0;
  localparam int CTL_TOGGLE  = 1;
  localparam int CTL_LINK    = 2;
  localparam int CTL_IRQ_LOC = 3;
  localparam int CTL_IRQ_REM = 4;
  localparam int CTL_BITS    = 5;

  localparam int SLOT_WORDS  = 6;
  localparam int SLOT_BYTES  = SLOT_WORDS * 4;

  localparam logic [1:0] CFG_PTR_LO = 2'd0;
  localparam logic [1:0] CFG_PTR_HI = 2'd1;
  localparam logic [1:0] CFG_CYCLE  = 2'd2;
  localparam logic [1:0] CFG_BELL   = 2'd3;

  typedef enum logic [1:0] {WK_IDLE, WK_HEAD, WK_BODY, WK_ISSUE} walk_state_e;
  typedef enum logic [1:0] {FT_IDLE, FT_REQ, FT_WAIT} fetch_state_e;

  typedef struct packed {
    logic        ptr_lo;
    logic        ptr_hi;
    logic        cyc;
    logic        bell;
    logic [31:0] data;
  } cfg_cmd_t;
endpackage

// File: rtl/llw_cfg_decode.sv
module llw_cfg_decode
  import llw_pkg::*;
(
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        busy_i,
  output cfg_cmd_t    cmd_o
);
  logic open_w;

  always_comb begin
    open_w      = cfg_we && !busy_i;
    cmd_o.data  = cfg_wdata;
    cmd_o.ptr_lo = open_w && (cfg_addr == CFG_PTR_LO);
    cmd_o.ptr_hi = open_w && (cfg_addr == CFG_PTR_HI);
    cmd_o.cyc    = open_w && (cfg_addr == CFG_CYCLE) && cfg_wdata[1];
    cmd_o.bell   = open_w && (cfg_addr == CFG_BELL) && cfg_wdata[0];
  end
endmodule

// File: rtl/llw_word_fetch.sv
module llw_word_fetch
  import llw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [31:0]       data_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  input  logic [31:0]       rsp_data_i
);
  fetch_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FT_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        FT_IDLE: if (go_i) begin
          addr_q <= addr_i;
          st_q   <= FT_REQ;
        end
        FT_REQ:  if (req_ready_i) st_q <= FT_WAIT;
        FT_WAIT: if (rsp_valid_i) st_q <= FT_IDLE;
        default: st_q <= FT_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == FT_REQ);
  assign req_addr_o  = addr_q;
  assign done_o      = (st_q == FT_WAIT) && rsp_valid_i;
  assign data_o      = rsp_data_i;
endmodule

// File: rtl/llw_walk_ctrl.sv
module llw_walk_ctrl
  import llw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_cmd_t          cfg_i,
  output logic              busy_o,
  output logic              cyc_state_o,
  output logic              abort_o,
  output logic              fetch_go_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_done_i,
  input  logic [31:0]       fetch_data_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [ADDR_W-1:0] cmd_src_o,
  output logic [ADDR_W-1:0] cmd_dst_o,
  output logic [31:0]       cmd_len_o,
  output logic [1:0]        irq_pulse_o
);
  localparam int IRQ_KINDS = 2;

  walk_state_e         st_q;
  logic [ADDR_W-1:0]   ptr_q;
  logic                ccs_q;
  logic                abort_q;
  logic                go_q;
  logic [2:0]          widx_q;
  logic [CTL_BITS-1:0] ctl_q;
  logic [31:0]         slot_q [1:4];
  logic                cmd_valid_q;
  logic [ADDR_W-1:0]   src_q, dst_q;
  logic [31:0]         len_q;
  logic [IRQ_KINDS-1:0] irq_q;

  logic [2:0]  last_idx_w;
  logic [63:0] ptr64_w, ptr_lo_w, ptr_hi_w, next_w, src_w, dst_w;

  always_comb begin
    last_idx_w = ctl_q[CTL_LINK] ? 3'd3 : 3'd5;
    ptr64_w    = 64'(ptr_q);
    ptr_lo_w   = {ptr64_w[63:32], cfg_i.data};
    ptr_hi_w   = {cfg_i.data, ptr64_w[31:0]};
    next_w     = {fetch_data_i, slot_q[2]};
    src_w      = {slot_q[3], slot_q[2]};
    dst_w      = {fetch_data_i, slot_q[4]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= WK_IDLE;
      ptr_q       <= '0;
      ccs_q       <= 1'b0;
      abort_q     <= 1'b0;
      go_q        <= 1'b0;
      widx_q      <= '0;
      ctl_q       <= '0;
      cmd_valid_q <= 1'b0;
      src_q       <= '0;
      dst_q       <= '0;
      len_q       <= '0;
      irq_q       <= '0;
      for (int k = 1; k <= 4; k++) slot_q[k] <= '0;
    end else begin
      go_q  <= 1'b0;
      irq_q <= '0;
      unique case (st_q)
        WK_IDLE: begin
          if (cfg_i.ptr_lo) ptr_q <= ptr_lo_w[ADDR_W-1:0];
          if (cfg_i.ptr_hi) ptr_q <= ptr_hi_w[ADDR_W-1:0];
          if (cfg_i.cyc)    ccs_q <= cfg_i.data[0];
          if (cfg_i.bell) begin
            abort_q <= 1'b0;
            widx_q  <= '0;
            go_q    <= 1'b1;
            st_q    <= WK_HEAD;
          end
        end
        WK_HEAD: if (fetch_done_i) begin
          ctl_q <= fetch_data_i[CTL_BITS-1:0];
          if (fetch_data_i[CTL_CYCLE] != ccs_q) begin
            st_q <= WK_IDLE;                 // not owned yet: park here
          end else begin
            widx_q <= fetch_data_i[CTL_LINK] ? 3'd2 : 3'd1;
            go_q   <= 1'b1;
            st_q   <= WK_BODY;
          end
        end
        WK_BODY: if (fetch_done_i) begin
          if (widx_q == last_idx_w) begin
            if (ctl_q[CTL_LINK]) begin
              ptr_q  <= next_w[ADDR_W-1:0];
              if (ctl_q[CTL_TOGGLE]) ccs_q <= ~ccs_q;
              widx_q <= '0;
              go_q   <= 1'b1;
              st_q   <= WK_HEAD;
            end else if (slot_q[1] == '0) begin
              abort_q <= 1'b1;
              st_q    <= WK_IDLE;
            end else begin
              cmd_valid_q <= 1'b1;
              src_q       <= src_w[ADDR_W-1:0];
              dst_q       <= dst_w[ADDR_W-1:0];
              len_q       <= slot_q[1];
              st_q        <= WK_ISSUE;
            end
          end else begin
            slot_q[widx_q] <= fetch_data_i;
            widx_q         <= 3'(widx_q + 3'd1);
            go_q           <= 1'b1;
          end
        end
        WK_ISSUE: if (cmd_ready_i) begin
          cmd_valid_q <= 1'b0;
          for (int k = 0; k < IRQ_KINDS; k++) irq_q[k] <= ctl_q[CTL_IRQ_LOC + k];
          ptr_q  <= ptr_q + ADDR_W'(SLOT_BYTES);
          widx_q <= '0;
          go_q   <= 1'b1;
          st_q   <= WK_HEAD;
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != WK_IDLE);
  assign cyc_state_o  = ccs_q;
  assign abort_o      = abort_q;
  assign fetch_go_o   = go_q;
  assign fetch_addr_o = ptr_q + (ADDR_W'(widx_q) << 2);
  assign cmd_valid_o  = cmd_valid_q;
  assign cmd_src_o    = src_q;
  assign cmd_dst_o    = dst_q;
  assign cmd_len_o    = len_q;
  assign irq_pulse_o  = irq_q;
endmodule

// File: rtl/lldma_walker.sv
module lldma_walker
  import llw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              busy,
  output logic              cycle_state,
  output logic              abort_seen,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src,
  output logic [ADDR_W-1:0] cmd_dst,
  output logic [31:0]       cmd_len,
  output logic              local_done,
  output logic              remote_done
);
  cfg_cmd_t          cfg_w;
  logic              go_w, done_w;
  logic [ADDR_W-1:0] faddr_w;
  logic [31:0]       fdata_w;
  logic [1:0]        irq_w;

  llw_cfg_decode u_dec (
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .busy_i    (busy),
    .cmd_o     (cfg_w)
  );

  llw_word_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go_w),
    .addr_i      (faddr_w),
    .done_o      (done_w),
    .data_o      (fdata_w),
    .req_valid_o (mem_req_valid),
    .req_ready_i (mem_req_ready),
    .req_addr_o  (mem_req_addr),
    .rsp_valid_i (mem_rsp_valid),
    .rsp_data_i  (mem_rsp_data)
  );

  llw_walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_w),
    .busy_o       (busy),
    .cyc_state_o  (cycle_state),
    .abort_o      (abort_seen),
    .fetch_go_o   (go_w),
    .fetch_addr_o (faddr_w),
    .fetch_done_i (done_w),
    .fetch_data_i (fdata_w),
    .cmd_valid_o  (cmd_valid),
    .cmd_ready_i  (cmd_ready),
    .cmd_src_o    (cmd_src),
    .cmd_dst_o    (cmd_dst),
    .cmd_len_o    (cmd_len),
    .irq_pulse_o  (irq_w)
  );

  assign local_done  = irq_w[0];
  assign remote_done = irq_w[1];
endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_src,
  input logic [ADDR_W-1:0] cmd_dst,
  input logic [31:0]       cmd_len,
  input logic              local_done,
  input logic              remote_done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid); // R4
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)); // R5
  AST_NO_EMPTY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != 32'd0); // R9
  AST_LOCAL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    local_done |-> $past(cmd_valid && cmd_ready)); // R8
  AST_REMOTE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    remote_done |-> $past(cmd_valid && cmd_ready)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    local_done || remote_done |=> !local_done && !remote_done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !mem_req_valid); // R6
endmodule

bind lldma_walker lldma_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
  .local_done(local_done), .remote_done(remote_done)
);

// File: tb/lldma_walker_test.sv
`timescale 1ns/1ps
module lldma_walker_test;
  localparam int ADDR_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              busy, cycle_state, abort_seen;
  logic              mem_req_valid, mem_req_ready;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;
  logic              cmd_valid, cmd_ready;
  logic [ADDR_W-1:0] cmd_src, cmd_dst;
  logic [31:0]       cmd_len;
  logic              local_done, remote_done;

  lldma_walker #(.ADDR_W(ADDR_W)) uut (.*);

  logic [31:0] mem [0:1023];
  logic [7:0]  tick = '0;
  logic        stall = 1'b0, hold = 1'b0;

  assign mem_req_ready = !hold && !(stall && tick[0]);
  assign cmd_ready     = !(stall && (tick[1] ^ tick[0]));

  always @(posedge clk) begin
    tick          <= tick + 8'd1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[11:2]];
  end

  int checks = 0, bad = 0;
  int ncap = 0, lcnt = 0, rcnt = 0, pbad = 0;
  logic [63:0] cap_src [0:15];
  logic [63:0] cap_dst [0:15];
  logic [31:0] cap_len [0:15];
  logic prev_hs = 1'b0;

  always @(posedge clk) begin
    if (cmd_valid && cmd_ready && ncap < 16) begin
      cap_src[ncap] <= cmd_src;
      cap_dst[ncap] <= cmd_dst;
      cap_len[ncap] <= cmd_len;
      ncap <= ncap + 1;
    end
    if (local_done)  begin lcnt <= lcnt + 1; if (!prev_hs) pbad <= pbad + 1; end
    if (remote_done) begin rcnt <= rcnt + 1; if (!prev_hs) pbad <= pbad + 1; end
    prev_hs <= cmd_valid && cmd_ready;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_caps();
    @(negedge clk);
    ncap = 0; lcnt = 0; rcnt = 0; pbad = 0;
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic ring(input logic [63:0] base);
    cfg_wr(2'd0, base[31:0]);
    cfg_wr(2'd1, base[63:32]);
    cfg_wr(2'd3, 32'h1);
    wait_idle();
  endtask

  task automatic put_data(input int a, input logic [31:0] ctl, input logic [31:0] sz,
                          input logic [63:0] s, input logic [63:0] d);
    mem[a/4]   = ctl; mem[a/4+1] = sz;
    mem[a/4+2] = s[31:0]; mem[a/4+3] = s[63:32];
    mem[a/4+4] = d[31:0]; mem[a/4+5] = d[63:32];
  endtask

  task automatic put_link(input int a, input logic [31:0] ctl, input logic [63:0] p);
    mem[a/4] = ctl; mem[a/4+1] = 32'h0;
    mem[a/4+2] = p[31:0]; mem[a/4+3] = p[63:32];
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 abort_seen", abort_seen, 0);
    chk("R1 pulses", {local_done, remote_done}, 0);
    chk("R1 cycle_state", cycle_state, 0);
  endtask

  task automatic t_cycle_sync();
    cfg_wr(2'd2, 32'h1);
    chk("R3 no load without bit1", cycle_state, 0);
    cfg_wr(2'd2, 32'h3);
    chk("R3 load one", cycle_state, 1);
    cfg_wr(2'd2, 32'h0);
    chk("R3 no load keeps one", cycle_state, 1);
  endtask

  task automatic t_single();
    clear_caps();
    put_data(32'h40, 32'h09, 32'h40, 64'h1234_5678_0000_0003, 64'h0000_00AB_CDEF_0001);
    put_data(32'h58, 32'h00, 32'h10, 64'h0, 64'h0);
    ring(64'h40);
    chk("R5 one command", ncap, 1);
    chk("R11 src odd", cap_src[0], 64'h1234_5678_0000_0003);
    chk("R11 dst odd", cap_dst[0], 64'h0000_00AB_CDEF_0001);
    chk("R5 len", cap_len[0], 32'h40);
    chk("R8 local count", lcnt, 1);
    chk("R8 remote count", rcnt, 0);
    chk("R8 pulse timing", pbad, 0);
    chk("R6 idle after mismatch", busy, 0);
  endtask

  task automatic t_chain_stall();
    clear_caps();
    stall = 1'b1;
    put_data(32'h80, 32'h11, 32'h8,  64'hA000_0000_0000_0010, 64'hB000_0000_0000_0020);
    put_data(32'h98, 32'h01, 32'h10, 64'hA000_0000_0000_0030, 64'hB000_0000_0000_0040);
    put_data(32'hB0, 32'h00, 32'h5,  64'h0, 64'h0);
    ring(64'h80);
    stall = 1'b0;
    chk("R10 two commands", ncap, 2);
    chk("R10 first len", cap_len[0], 32'h8);
    chk("R10 second src", cap_src[1], 64'hA000_0000_0000_0030);
    chk("R5 second dst", cap_dst[1], 64'hB000_0000_0000_0040);
    chk("R8 remote count", rcnt, 1);
    chk("R8 local none", lcnt, 0);
    chk("R8 pulse timing stall", pbad, 0);
  endtask

  task automatic t_link_toggle();
    clear_caps();
    put_data(32'h100, 32'h01, 32'h4, 64'h11, 64'h22);
    put_link(32'h118, 32'h07, 64'h200);
    put_data(32'h200, 32'h00, 32'h5, 64'h33, 64'h44);
    put_data(32'h218, 32'h01, 32'h6, 64'h55, 64'h66);
    ring(64'h100);
    chk("R7 toggle path commands", ncap, 2);
    chk("R7 jumped element", cap_src[1], 64'h33);
    chk("R7 state inverted", cycle_state, 0);
  endtask

  task automatic t_link_keep();
    clear_caps();
    put_link(32'h280, 32'h04, 64'h300);
    put_data(32'h300, 32'h08, 32'h7, 64'h77, 64'h88);
    put_data(32'h318, 32'h01, 32'h9, 64'h99, 64'hAA);
    ring(64'h280);
    chk("R7 keep path commands", ncap, 1);
    chk("R7 keep len", cap_len[0], 32'h7);
    chk("R7 state kept", cycle_state, 0);
    chk("R8 local on link path", lcnt, 1);
  endtask

  task automatic t_resume();
    clear_caps();
    mem[32'h318/4] = 32'h00;
    mem[32'h330/4] = 32'h01;
    cfg_wr(2'd3, 32'h1);
    wait_idle();
    chk("R6 resumed at parked element", ncap, 1);
    chk("R6 resumed len", cap_len[0], 32'h9);
  endtask

  task automatic t_busy_ignore();
    clear_caps();
    put_data(32'h380, 32'h00, 32'h3, 64'h123, 64'h456);
    put_data(32'h398, 32'h01, 32'h1, 64'h0, 64'h0);
    cfg_wr(2'd0, 32'h380);
    cfg_wr(2'd1, 32'h0);
    hold = 1'b1;
    cfg_wr(2'd3, 32'h1);
    chk("R2 busy after doorbell", busy, 1);
    cfg_wr(2'd0, 32'h40);
    cfg_wr(2'd2, 32'h3);
    chk("R2 cycle write ignored while busy", cycle_state, 0);
    hold = 1'b0;
    wait_idle();
    chk("R2 pointer write ignored", ncap, 1);
    chk("R2 original list used", cap_len[0], 32'h3);
    chk("R2 state unchanged", cycle_state, 0);
  endtask

  task automatic t_abort();
    clear_caps();
    put_data(32'h3C0, 32'h00, 32'h0, 64'h1, 64'h2);
    put_data(32'h3D8, 32'h00, 32'h2, 64'h5, 64'h6);
    put_data(32'h3F0, 32'h01, 32'h1, 64'h0, 64'h0);
    ring(64'h3C0);
    chk("R9 abort flag", abort_seen, 1);
    chk("R9 no command", ncap, 0);
    chk("R9 halted", busy, 0);
    ring(64'h3D8);
    chk("R9 abort cleared by doorbell", abort_seen, 0);
    chk("R9 later list runs", ncap, 1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=hung expected=idle");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cycle_sync();
    t_single();
    t_chain_stall();
    t_link_toggle();
    t_link_keep();
    t_resume();
    t_busy_ignore();
    t_abort();
    finish_run();
  end
endmodule